// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the program counter of a 32-bit processor whose instructions are four bytes long and word aligned. Each cycle it looks at the instruction word at the current fetch address and at the two register operands read for it. From these it picks the next fetch address from one of four paths: the next sequential word, a PC-relative conditional branch, an absolute jump inside the current 256 MB region, or a jump to an address held in a register.

Every target is computed from the address of the following instruction (current PC plus 4). Branch offsets are counted in words. A stall input freezes the counter. A register jump to an address that is not a multiple of four raises a flag, and the two low bits are cleared before the address is used.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_n` is low, `fetch_addr` equals `RESET_VEC` (default 0). The reset takes effect without waiting for a clock edge.
- R2: On a rising edge with `stall` high, `fetch_addr` keeps its value whatever the instruction is.
- R3: On a rising edge without stall, `fetch_addr` advances by 4 in three cases. The first is any opcode (`instr[31:26]`) other than 0, 2, 4 and 5. The second is opcode 0 with a function code (`instr[5:0]`) other than 8. The third is a branch that is not taken.
- R4: Opcode 4 with `rs_val == rt_val` loads PC+4 plus the value `{instr[15:0],2'b00}` sign-extended from 18 bits.
- R5: Opcode 5 with `rs_val != rt_val` loads the same branch target as R4.
- R6: Offset 16'h8000 moves the PC by -131068 bytes from the branch (-2^17 from PC+4). Offset 16'h7FFF moves it by +131072 (2^17-4 from PC+4). Addition wraps modulo 2^32.
- R7: Opcode 2 loads `{PC+4[31:28], instr[25:0], 2'b00}`.
- R8: Opcode 0 with function code 8 loads `rs_val` with bits [1:0] forced to 0.
- R9: `misalign` is high in the same cycle (combinationally) exactly when the instruction is a register jump (R8) and `rs_val[1:0]` is nonzero. This holds independently of `stall`.
- R10: `fetch_addr[1:0]` is always 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| stall | input | 1 | Hold the PC this cycle |
| instr | input | 32 | Instruction word at `fetch_addr` |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| fetch_addr | output | 32 | Current PC / fetch address |
| misalign | output | 1 | Register-jump target not word aligned |

## Verification
A stall can arrive in the same cycle as a taken branch, an absolute jump or a register jump. The stall must win and the PC must stay put. The misalign flag must still report a bad register-jump target during a stall. The random stream raises stall on about one cycle in eight over a mix in which most instructions transfer control, so this collision happens hundreds of times. Each case is judged against a reference next-PC function that returns the old PC whenever stall is high, and the flag is checked in every cycle regardless of stall.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_ABSJ    = 6'd2;
  localparam logic [5:0] OP_BR_EQ   = 6'd4;
  localparam logic [5:0] OP_BR_NE   = 6'd5;
  localparam logic [5:0] FN_REGJ    = 6'd8;

  typedef enum logic [1:0] {
    NXT_SEQ = 2'd0,
    NXT_BR  = 2'd1,
    NXT_ABS = 2'd2,
    NXT_REG = 2'd3
  } nxt_sel_e;
endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
  import pcu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [5:0]        opcode,
  input  logic [5:0]        funct,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output nxt_sel_e          sel,
  output logic              bad_align
);
  logic operands_eq;
  logic is_regj;

  always_comb begin
    operands_eq = (src_a == src_b);
    is_regj     = (opcode == OP_SPECIAL) && (funct == FN_REGJ);
    sel         = NXT_SEQ;
    unique case (opcode)
      OP_BR_EQ:   if (operands_eq)  sel = NXT_BR;
      OP_BR_NE:   if (!operands_eq) sel = NXT_BR;
      OP_ABSJ:    sel = NXT_ABS;
      OP_SPECIAL: if (is_regj) sel = NXT_REG;
      default:    sel = NXT_SEQ;
    endcase
    bad_align = is_regj && (src_a[1:0] != 2'b00);
  end
endmodule

// File: rtl/pcu_target.sv
module pcu_target
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 26
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [IMM_W-1:0]  offset,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic [ADDR_W-3:0] reg_word,
  input  nxt_sel_e          sel,
  output logic [ADDR_W-1:0] pc_nxt
);
  localparam int EXT_W  = ADDR_W - IMM_W - 2;
  localparam int HIGH_W = ADDR_W - IDX_W - 2;

  logic [ADDR_W-1:0] pc_inc;
  logic [ADDR_W-1:0] br_disp;
  logic [ADDR_W-1:0] br_tgt;
  logic [ADDR_W-1:0] abs_tgt;
  logic [ADDR_W-1:0] reg_tgt;

  always_comb begin
    pc_inc  = pc + ADDR_W'(4);
    br_disp = {{EXT_W{offset[IMM_W-1]}}, offset, 2'b00};
    br_tgt  = pc_inc + br_disp;
    abs_tgt = {pc_inc[ADDR_W-1 -: HIGH_W], word_idx, 2'b00};
    reg_tgt = {reg_word, 2'b00};
    unique case (sel)
      NXT_BR:  pc_nxt = br_tgt;
      NXT_ABS: pc_nxt = abs_tgt;
      NXT_REG: pc_nxt = reg_tgt;
      default: pc_nxt = pc_inc;
    endcase
  end
endmodule

// File: rtl/pcu_reg.sv
module pcu_reg #(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] RESET_VEC = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  logic              load_en;
  logic [ADDR_W-1:0] q_d;

  always_comb begin
    load_en = !hold;
    q_d     = load_en ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RESET_VEC[ADDR_W-1:0];
    else        q <= q_d;
  end

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(q));
  p_word_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    q[1:0] == 2'b00);
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcu_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] RESET_VEC = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic [31:0]       instr,
  input  logic [ADDR_W-1:0] rs_val,
  input  logic [ADDR_W-1:0] rt_val,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              misalign
);
  localparam int IMM_W = 16;
  localparam int IDX_W = 26;

  nxt_sel_e          sel;
  logic [ADDR_W-1:0] pc_nxt;

  pcu_decode #(.DATA_W(ADDR_W)) u_dec (
    .opcode    (instr[31:26]),
    .funct     (instr[5:0]),
    .src_a     (rs_val),
    .src_b     (rt_val),
    .sel       (sel),
    .bad_align (misalign)
  );

  pcu_target #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_tgt (
    .pc       (fetch_addr),
    .offset   (instr[IMM_W-1:0]),
    .word_idx (instr[IDX_W-1:0]),
    .reg_word (rs_val[ADDR_W-1:2]),
    .sel      (sel),
    .pc_nxt   (pc_nxt)
  );

  pcu_reg #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (stall),
    .d     (pc_nxt),
    .q     (fetch_addr)
  );

  p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && sel == NXT_SEQ) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(4));
  p_abs_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && sel == NXT_ABS) |=> fetch_addr[IDX_W+1:2] == $past(instr[IDX_W-1:0]));
  p_flag_regj_r9: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> sel == NXT_REG);
  p_regj_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && sel == NXT_REG) |=> fetch_addr[ADDR_W-1:2] == $past(rs_val[ADDR_W-1:2]));
endmodule

// File: tb/pc_next_unit_test.sv
module pc_next_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic [31:0] instr = 32'h0;
  logic [31:0] rs_val = 32'h0;
  logic [31:0] rt_val = 32'h0;
  logic [31:0] fetch_addr;
  logic        misalign;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] mpc = 32'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_next_unit uut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val), .fetch_addr(fetch_addr), .misalign(misalign)
  );

  function automatic logic [31:0] ref_next(input logic [31:0] pc, input logic [31:0] ins,
                                           input logic [31:0] a, input logic [31:0] b,
                                           input logic st);
    logic [31:0] inc;
    logic [31:0] disp;
    inc  = pc + 32'd4;
    disp = {{14{ins[15]}}, ins[15:0], 2'b00};
    if (st) return pc;
    case (ins[31:26])
      6'd4: return (a == b) ? inc + disp : inc;
      6'd5: return (a != b) ? inc + disp : inc;
      6'd2: return {inc[31:28], ins[25:0], 2'b00};
      6'd0: return (ins[5:0] == 6'd8) ? {a[31:2], 2'b00} : inc;
      default: return inc;
    endcase
  endfunction

  function automatic logic ref_flag(input logic [31:0] ins, input logic [31:0] a);
    return (ins[31:26] == 6'd0) && (ins[5:0] == 6'd8) && (a[1:0] != 2'b00);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Entered at a falling edge; leaves at the next falling edge.
  task automatic step(input string req, input logic [31:0] ins, input logic [31:0] a,
                      input logic [31:0] b, input logic st);
    logic [31:0] exp;
    instr = ins; rs_val = a; rt_val = b; stall = st;
    exp = ref_next(mpc, ins, a, b, st);
    #1;
    chk("R9 flag", {31'd0, misalign}, {31'd0, ref_flag(ins, a)});
    @(posedge clk);
    @(negedge clk);
    chk(req, fetch_addr, exp);
    chk("R10 align", {30'd0, fetch_addr[1:0]}, 32'd0);
    mpc = exp;
  endtask

  function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [25:0] rest);
    return {op, rest};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (2) @(negedge clk);
    chk("R1 reset", fetch_addr, 32'h0);
    rst_n = 1'b1;
    mpc = 32'h0;

    // R3 sequential cases
    step("R3 plain", mk_i(6'd8, 26'h12345), 32'h1, 32'h2, 1'b0);
    step("R3 op0 other funct", mk_i(6'd0, 26'h0000020), 32'h3, 32'h3, 1'b0);
    step("R3 beq not taken", mk_i(6'd4, 26'h0000010), 32'h5, 32'h6, 1'b0);
    step("R3 bne not taken", mk_i(6'd5, 26'h0000010), 32'h7, 32'h7, 1'b0);
    // R4 / R5 taken
    step("R4 beq taken", mk_i(6'd4, 26'h0000010), 32'h9, 32'h9, 1'b0);
    step("R5 bne taken", mk_i(6'd5, 26'h000FFFE), 32'h1, 32'h2, 1'b0);
    // R8 register jump to a high region, then R6 extremes
    step("R8 regj", mk_i(6'd0, 26'h0000008), 32'h4000_0000, 32'h0, 1'b0);
    step("R6 min offset", mk_i(6'd4, 26'h0008000), 32'h1, 32'h1, 1'b0);
    chk("R6 min value", fetch_addr, 32'h4000_0004 - 32'd131072);
    step("R6 max offset", mk_i(6'd5, 26'h0007FFF), 32'h1, 32'h0, 1'b0);
    // R7 keeps upper bits of PC+4
    step("R8 regj high", mk_i(6'd0, 26'h0000008), 32'hF000_0100, 32'h0, 1'b0);
    step("R7 abs jump", mk_i(6'd2, 26'h3FF_FFFF), 32'h0, 32'h0, 1'b0);
    chk("R7 value", fetch_addr, 32'hFFFF_FFFC);
    step("R6 wrap", mk_i(6'd8, 26'h0), 32'h0, 32'h0, 1'b0);
    // R9 misaligned register jump
    step("R9 misaligned regj", mk_i(6'd0, 26'h0000008), 32'h1234_5677, 32'h0, 1'b0);
    chk("R9 cleared", fetch_addr, 32'h1234_5674);
    // R2 stall over control transfer and misaligned jr
    step("R2 stall beq", mk_i(6'd4, 26'h0000100), 32'h1, 32'h1, 1'b1);
    step("R2 stall regj", mk_i(6'd0, 26'h0000008), 32'h0000_0A01, 32'h0, 1'b1);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b, ins;
      logic st;
      int kind;
      a = $urandom; b = ($urandom_range(0, 1) == 1) ? a : $urandom;
      st = ($urandom_range(0, 7) == 0);
      kind = $urandom_range(0, 5);
      ins = $urandom;
      case (kind)
        0: ins[31:26] = 6'd4;
        1: ins[31:26] = 6'd5;
        2: ins[31:26] = 6'd2;
        3: begin ins[31:26] = 6'd0; ins[5:0] = 6'd8; end
        4: begin ins[31:26] = 6'd0; if (ins[5:0] == 6'd8) ins[5:0] = 6'd9; end
        default: if (ins[31:26] inside {6'd0, 6'd2, 6'd4, 6'd5}) ins[31:26] = 6'd35;
      endcase
      step(st ? "R2 random" : "R3-R8 random", ins, a, b, st);
    end

    // R1 asynchronous reset mid-run
    #2 rst_n = 1'b0;
    #1 chk("R1 async reset", fetch_addr, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    mpc = 32'h0;
    step("R3 after reset", mk_i(6'd9, 26'h0), 32'h0, 32'h0, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule